// File: doc/BRIEF.md
# Stall-Gated Read Request Shim

This block sits on one DMA read path, between the DMA engine's read-address channel and a crossbar port that several DMA engines share in front of one memory slave. When the stream that consumes this DMA's data stalls, the DMA has no room for more read responses. If a request were still accepted, its response would sit at the crossbar, and the crossbar would stop serving every other master. With several streams feeding one consumer that needs all of them, that wait can close into a deadlock.

The shim takes the stream consumer's ready as a gate on the address handshake. The gate acts on both sides. Toward the DMA, the crossbar's address-ready is masked, so the DMA sees a busy slave. Toward the crossbar, the DMA's address-valid is masked, so the crossbar sees no request. Requests are single beats, so every accepted request brings back exactly one response beat.

Address, length, size, burst type and ID go through unchanged and without registers. The whole read-data channel also goes through untouched. The gate may drop a request that is still pending toward the crossbar. This knowingly relaxes the usual rule that a valid, once raised, stays asserted until it is accepted.

Top module: `stall_gated_rd_shim`

## Requirements
- R1: `up_arready` equals `dn_arready` AND `strm_ready` in every cycle.
- R2: `dn_arvalid` equals `up_arvalid` AND `strm_ready` in every cycle.
- R3: No address handshake completes on either side in a cycle where `strm_ready` is low. An upstream handshake and a downstream handshake always fall in the same cycle.
- R4: `dn_araddr`, `dn_arlen`, `dn_arsize`, `dn_arburst` and `dn_arid` equal their upstream counterparts in the same cycle. Requests carry a length field of 0, which means one beat.
- R5: `up_rvalid`, `up_rdata`, `up_rresp`, `up_rlast` and `up_rid` equal their downstream counterparts, and `dn_rready` equals `up_rready`. This holds whatever the value of `strm_ready`.
- R6: Four DMA paths, each with its own shim, share one single-outstanding crossbar. While one path's stream is held stalled, the other three finish all their reads and the stalled path issues nothing. Once the stall is released, the stalled path also finishes.
- R7: A pending request that loses `strm_ready` is withdrawn from the crossbar. When `strm_ready` returns, it reappears with identical fields and can then be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, used only by the embedded checks |
| strm_ready | input | 1 | Ready of the stream consumer fed by this DMA; the gate |
| up_arvalid | input | 1 | Read request valid from the DMA |
| up_arready | output | 1 | Gated request ready toward the DMA |
| up_araddr | input | ADDR_W | Request address from the DMA |
| up_arlen | input | LEN_W | Request length from the DMA (0 = one beat) |
| up_arsize | input | 3 | Request beat size from the DMA |
| up_arburst | input | 2 | Request burst type from the DMA |
| up_arid | input | ID_W | Request ID from the DMA |
| dn_arvalid | output | 1 | Gated request valid toward the crossbar |
| dn_arready | input | 1 | Request ready from the crossbar |
| dn_araddr | output | ADDR_W | Request address toward the crossbar |
| dn_arlen | output | LEN_W | Request length toward the crossbar |
| dn_arsize | output | 3 | Request beat size toward the crossbar |
| dn_arburst | output | 2 | Request burst type toward the crossbar |
| dn_arid | output | ID_W | Request ID toward the crossbar |
| dn_rvalid | input | 1 | Read data valid from the crossbar |
| dn_rready | output | 1 | Read data ready toward the crossbar |
| dn_rdata | input | DATA_W | Read data from the crossbar |
| dn_rresp | input | 2 | Read response from the crossbar |
| dn_rlast | input | 1 | Last beat flag from the crossbar |
| dn_rid | input | ID_W | Read ID from the crossbar |
| up_rvalid | output | 1 | Read data valid toward the DMA |
| up_rready | input | 1 | Read data ready from the DMA |
| up_rdata | output | DATA_W | Read data toward the DMA |
| up_rresp | output | 2 | Read response toward the DMA |
| up_rlast | output | 1 | Last beat flag toward the DMA |
| up_rid | output | ID_W | Read ID toward the DMA |

## Verification
The embedded checks assume two things about the DMA side. First, every request carries a length of zero. Second, a request that is raised and not yet accepted upstream keeps its valid asserted and keeps its address and ID stable until it is accepted. Because of the second assumption, a dropped downstream valid can only come from the gate and never from the DMA. The bench's DMA stubs produce addresses from a sent-count that advances only on an upstream handshake, and always use a length of zero. The directed stimulus changes the address only in the cycle after a handshake.

// File: rtl/srs_pkg.sv
package srs_pkg;

    // Length field value that encodes a single-beat request
    localparam int SINGLE_BEAT_LEN = 0;

    // A handshake signal passes only while the gate is open
    function automatic logic gate_pass(input logic sig, input logic open_gate);
        return sig & open_gate;
    endfunction

endpackage

// File: rtl/rd_addr_gate.sv
module rd_addr_gate
    import srs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_open,
    input  logic              up_arvalid,
    output logic              up_arready,
    input  logic [ADDR_W-1:0] up_araddr,
    input  logic [LEN_W-1:0]  up_arlen,
    input  logic [2:0]        up_arsize,
    input  logic [1:0]        up_arburst,
    input  logic [ID_W-1:0]   up_arid,
    output logic              dn_arvalid,
    input  logic              dn_arready,
    output logic [ADDR_W-1:0] dn_araddr,
    output logic [LEN_W-1:0]  dn_arlen,
    output logic [2:0]        dn_arsize,
    output logic [1:0]        dn_arburst,
    output logic [ID_W-1:0]   dn_arid
);

    // Handshake gating: both directions masked by the stream-side ready
    always_comb begin
        dn_arvalid = gate_pass(up_arvalid, gate_open);
        up_arready = gate_pass(dn_arready, gate_open);
    end

    // Request fields go straight through
    always_comb begin
        dn_araddr  = up_araddr;
        dn_arlen   = up_arlen;
        dn_arsize  = up_arsize;
        dn_arburst = up_arburst;
        dn_arid    = up_arid;
    end

    logic up_hs, dn_hs;
    assign up_hs = up_arvalid && up_arready;
    assign dn_hs = dn_arvalid && dn_arready;

    assert_no_hs_in_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> (!up_hs && !dn_hs));

    assert_hs_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
        up_hs == dn_hs);

    assert_single_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        up_arvalid |-> (up_arlen == LEN_W'(SINGLE_BEAT_LEN)));

    // Input assumption: the DMA holds its request until accepted upstream
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_arvalid && !up_arready) |=> (up_arvalid && $stable(up_araddr) && $stable(up_arid)));

endmodule

// File: rtl/rd_data_pass.sv
module rd_data_pass #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dn_rvalid,
    output logic              dn_rready,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic [1:0]        dn_rresp,
    input  logic              dn_rlast,
    input  logic [ID_W-1:0]   dn_rid,
    output logic              up_rvalid,
    input  logic              up_rready,
    output logic [DATA_W-1:0] up_rdata,
    output logic [1:0]        up_rresp,
    output logic              up_rlast,
    output logic [ID_W-1:0]   up_rid
);

    always_comb begin
        up_rvalid = dn_rvalid;
        up_rdata  = dn_rdata;
        up_rresp  = dn_rresp;
        up_rlast  = dn_rlast;
        up_rid    = dn_rid;
        dn_rready = up_rready;
    end

    assert_beat_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_rvalid && dn_rready) == (up_rvalid && up_rready));

    assert_beat_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |-> up_rlast);

endmodule

// File: rtl/stall_gated_rd_shim.sv
module stall_gated_rd_shim #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strm_ready,
    input  logic              up_arvalid,
    output logic              up_arready,
    input  logic [ADDR_W-1:0] up_araddr,
    input  logic [LEN_W-1:0]  up_arlen,
    input  logic [2:0]        up_arsize,
    input  logic [1:0]        up_arburst,
    input  logic [ID_W-1:0]   up_arid,
    output logic              dn_arvalid,
    input  logic              dn_arready,
    output logic [ADDR_W-1:0] dn_araddr,
    output logic [LEN_W-1:0]  dn_arlen,
    output logic [2:0]        dn_arsize,
    output logic [1:0]        dn_arburst,
    output logic [ID_W-1:0]   dn_arid,
    input  logic              dn_rvalid,
    output logic              dn_rready,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic [1:0]        dn_rresp,
    input  logic              dn_rlast,
    input  logic [ID_W-1:0]   dn_rid,
    output logic              up_rvalid,
    input  logic              up_rready,
    output logic [DATA_W-1:0] up_rdata,
    output logic [1:0]        up_rresp,
    output logic              up_rlast,
    output logic [ID_W-1:0]   up_rid
);

    rd_addr_gate #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W)) u_addr_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_open  (strm_ready),
        .up_arvalid (up_arvalid),
        .up_arready (up_arready),
        .up_araddr  (up_araddr),
        .up_arlen   (up_arlen),
        .up_arsize  (up_arsize),
        .up_arburst (up_arburst),
        .up_arid    (up_arid),
        .dn_arvalid (dn_arvalid),
        .dn_arready (dn_arready),
        .dn_araddr  (dn_araddr),
        .dn_arlen   (dn_arlen),
        .dn_arsize  (dn_arsize),
        .dn_arburst (dn_arburst),
        .dn_arid    (dn_arid)
    );

    rd_data_pass #(.DATA_W(DATA_W), .ID_W(ID_W)) u_data_pass (
        .clk       (clk),
        .rst_n     (rst_n),
        .dn_rvalid (dn_rvalid),
        .dn_rready (dn_rready),
        .dn_rdata  (dn_rdata),
        .dn_rresp  (dn_rresp),
        .dn_rlast  (dn_rlast),
        .dn_rid    (dn_rid),
        .up_rvalid (up_rvalid),
        .up_rready (up_rready),
        .up_rdata  (up_rdata),
        .up_rresp  (up_rresp),
        .up_rlast  (up_rlast),
        .up_rid    (up_rid)
    );

endmodule

// File: tb/stall_gated_rd_shim_tb.sv
`timescale 1ns/1ps
module stall_gated_rd_shim_tb;

    localparam int NP = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int IW = 4;
    localparam logic [31:0] MAGIC = 32'hA5A5_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;

    // direct-mode drive for path 0
    logic xbar_on = 1'b0;
    logic d_strm = 1'b0, d_arvalid = 1'b0, d_arready = 1'b0, d_rvalid = 1'b0, d_rready = 1'b0, d_rlast = 1'b0;
    logic [AW-1:0] d_araddr = '0;
    logic [2:0] d_arsize = '0;
    logic [1:0] d_arburst = '0, d_rresp = '0;
    logic [IW-1:0] d_arid = '0, d_rid = '0;
    logic [DW-1:0] d_rdata = '0;

    logic [NP-1:0] hold = '0;
    logic [7:0] want [NP];
    logic [7:0] sent [NP];
    logic [7:0] rcvd [NP];
    logic [15:0] lfsr;

    logic [NP-1:0] strm_rdy, up_arvalid, up_arready, dn_arvalid, dn_arready;
    logic [NP-1:0] dn_rvalid, dn_rready, up_rvalid, up_rready, up_rlast, dn_rlast;
    logic [AW-1:0] up_araddr [NP];
    logic [AW-1:0] dn_araddr [NP];
    logic [LW-1:0] dn_arlen [NP];
    logic [2:0] up_arsize [NP];
    logic [2:0] dn_arsize [NP];
    logic [1:0] up_arburst [NP];
    logic [1:0] dn_arburst [NP];
    logic [1:0] dn_rresp [NP];
    logic [1:0] up_rresp [NP];
    logic [IW-1:0] up_arid [NP];
    logic [IW-1:0] dn_arid [NP];
    logic [IW-1:0] dn_rid [NP];
    logic [IW-1:0] up_rid [NP];
    logic [DW-1:0] dn_rdata [NP];
    logic [DW-1:0] up_rdata [NP];

    // crossbar stub: one outstanding request, round robin
    logic busy;
    logic [1:0] owner, rr, gnt;
    logic gnt_vld;
    logic [DW-1:0] xb_data;
    logic [IW-1:0] xb_id;

    always_comb begin
        gnt_vld = 1'b0;
        gnt = rr;
        for (int k = 0; k < NP; k++) begin
            logic [1:0] idx;
            idx = rr + 2'(k);
            if (!gnt_vld && dn_arvalid[idx]) begin
                gnt_vld = 1'b1;
                gnt = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; owner <= '0; rr <= '0; xb_data <= '0; xb_id <= '0;
        end else if (xbar_on) begin
            if (!busy && gnt_vld) begin
                busy <= 1'b1;
                owner <= gnt;
                xb_data <= dn_araddr[gnt] ^ MAGIC;
                xb_id <= dn_arid[gnt];
            end else if (busy && dn_rready[owner]) begin
                busy <= 1'b0;
                rr <= owner + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= 16'hACE1;
        else lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    for (genvar g = 0; g < NP; g++) begin : g_path
        logic [AW-1:0] base;
        assign base = 32'h1000_0000 * (g + 1);

        always_comb begin
            if (xbar_on) begin
                strm_rdy[g]   = hold[g] ? 1'b0 : (lfsr[g] | lfsr[g+4]);
                up_arvalid[g] = sent[g] < want[g];
                up_araddr[g]  = base + {22'd0, sent[g], 2'b00};
                up_arsize[g]  = 3'd2;
                up_arburst[g] = 2'b01;
                up_arid[g]    = IW'(g);
                up_rready[g]  = strm_rdy[g];
                dn_arready[g] = !busy && gnt_vld && (gnt == 2'(g));
                dn_rvalid[g]  = busy && (owner == 2'(g));
                dn_rdata[g]   = xb_data;
                dn_rresp[g]   = 2'b00;
                dn_rlast[g]   = 1'b1;
                dn_rid[g]     = xb_id;
            end else if (g == 0) begin
                strm_rdy[g]   = d_strm;
                up_arvalid[g] = d_arvalid;
                up_araddr[g]  = d_araddr;
                up_arsize[g]  = d_arsize;
                up_arburst[g] = d_arburst;
                up_arid[g]    = d_arid;
                up_rready[g]  = d_rready;
                dn_arready[g] = d_arready;
                dn_rvalid[g]  = d_rvalid;
                dn_rdata[g]   = d_rdata;
                dn_rresp[g]   = d_rresp;
                dn_rlast[g]   = d_rlast;
                dn_rid[g]     = d_rid;
            end else begin
                strm_rdy[g] = 1'b0; up_arvalid[g] = 1'b0; up_araddr[g] = '0;
                up_arsize[g] = '0; up_arburst[g] = '0; up_arid[g] = '0;
                up_rready[g] = 1'b0; dn_arready[g] = 1'b0; dn_rvalid[g] = 1'b0;
                dn_rdata[g] = '0; dn_rresp[g] = '0; dn_rlast[g] = 1'b0; dn_rid[g] = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n || !xbar_on) begin
                sent[g] <= '0;
                rcvd[g] <= '0;
            end else begin
                if (up_arvalid[g] && up_arready[g]) sent[g] <= sent[g] + 8'd1;
                if (up_rvalid[g] && up_rready[g]) rcvd[g] <= rcvd[g] + 8'd1;
            end
        end

        stall_gated_rd_shim #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .ID_W(IW)) u_dut (
            .clk(clk), .rst_n(rst_n), .strm_ready(strm_rdy[g]),
            .up_arvalid(up_arvalid[g]), .up_arready(up_arready[g]), .up_araddr(up_araddr[g]),
            .up_arlen('0), .up_arsize(up_arsize[g]), .up_arburst(up_arburst[g]), .up_arid(up_arid[g]),
            .dn_arvalid(dn_arvalid[g]), .dn_arready(dn_arready[g]), .dn_araddr(dn_araddr[g]),
            .dn_arlen(dn_arlen[g]), .dn_arsize(dn_arsize[g]), .dn_arburst(dn_arburst[g]), .dn_arid(dn_arid[g]),
            .dn_rvalid(dn_rvalid[g]), .dn_rready(dn_rready[g]), .dn_rdata(dn_rdata[g]),
            .dn_rresp(dn_rresp[g]), .dn_rlast(dn_rlast[g]), .dn_rid(dn_rid[g]),
            .up_rvalid(up_rvalid[g]), .up_rready(up_rready[g]), .up_rdata(up_rdata[g]),
            .up_rresp(up_rresp[g]), .up_rlast(up_rlast[g]), .up_rid(up_rid[g])
        );
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard
    logic [DW-1:0] exp_q [NP][$];
    int stall_hs = 0;

    task automatic push_expected(input int p, input int n);
        for (int k = 0; k < n; k++)
            exp_q[p].push_back((32'h1000_0000 * (p + 1) + 32'(k * 4)) ^ MAGIC);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (xbar_on && rst_n) begin
                for (int p = 0; p < NP; p++) begin
                    if (dn_arvalid[p] && dn_arready[p] && !strm_rdy[p]) stall_hs++;
                    if (up_rvalid[p] && up_rready[p]) begin
                        if (exp_q[p].size() == 0) chk(1'b0, "R6 unexpected beat", 64'(up_rdata[p]), 64'd0);
                        else begin
                            logic [DW-1:0] e;
                            e = exp_q[p].pop_front();
                            chk(up_rdata[p] == e, "R6 data", 64'(up_rdata[p]), 64'(e));
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) want[p] = 8'd0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // reset state / R2: nothing requested
        chk(dn_arvalid[0] == 1'b0, "R2 idle valid", 64'(dn_arvalid[0]), 64'd0);

        // stalled: both sides masked (R1, R2, R3)
        @(negedge clk);
        d_arvalid = 1'b1; d_arready = 1'b1; d_strm = 1'b0;
        d_araddr = 32'h0000_1234; d_arid = 4'h5; d_arsize = 3'd2; d_arburst = 2'b01;
        #1;
        chk(up_arready[0] == 1'b0, "R1 ready masked", 64'(up_arready[0]), 64'd0);
        chk(dn_arvalid[0] == 1'b0, "R2 valid masked R3", 64'(dn_arvalid[0]), 64'd0);
        // crossbar busy, gate open: ready follows crossbar
        @(negedge clk);
        d_arready = 1'b0; d_strm = 1'b1; #1;
        chk(up_arready[0] == 1'b0, "R1 crossbar busy", 64'(up_arready[0]), 64'd0);
        chk(dn_arvalid[0] == 1'b1, "R2 valid open", 64'(dn_arvalid[0]), 64'd1);
        chk(dn_araddr[0] == 32'h0000_1234 && dn_arid[0] == 4'h5, "R4 addr/id",
            64'({dn_araddr[0], dn_arid[0]}), 64'({32'h0000_1234, 4'h5}));
        chk(dn_arsize[0] == 3'd2 && dn_arburst[0] == 2'b01 && dn_arlen[0] == 8'd0, "R4 size/burst/len",
            64'({dn_arsize[0], dn_arburst[0], dn_arlen[0]}), 64'({3'd2, 2'b01, 8'd0}));
        // withdraw on stall, reappear unchanged (R7)
        @(negedge clk);
        d_strm = 1'b0; #1;
        chk(dn_arvalid[0] == 1'b0, "R7 withdrawn", 64'(dn_arvalid[0]), 64'd0);
        @(negedge clk);
        d_strm = 1'b1; #1;
        chk(dn_arvalid[0] == 1'b1 && dn_araddr[0] == 32'h0000_1234, "R7 reappears",
            64'({dn_arvalid[0], dn_araddr[0]}), 64'({1'b1, 32'h0000_1234}));
        // accept: both sides see a handshake (R1, R3)
        @(negedge clk);
        d_arready = 1'b1; #1;
        chk(up_arready[0] == 1'b1 && dn_arvalid[0] == 1'b1, "R1 R3 handshake",
            64'({up_arready[0], dn_arvalid[0]}), 64'd3);
        @(negedge clk);
        d_arvalid = 1'b0; d_araddr = 32'h0000_5678; d_arid = 4'h9; d_arsize = 3'd3; d_arburst = 2'b00;
        #1;
        chk(dn_araddr[0] == 32'h0000_5678 && dn_arid[0] == 4'h9 && dn_arsize[0] == 3'd3,
            "R4 second pattern", 64'({dn_araddr[0], dn_arid[0]}), 64'({32'h0000_5678, 4'h9}));
        // read-data passes while stalled (R5)
        @(negedge clk);
        d_strm = 1'b0; d_arready = 1'b0;
        d_rvalid = 1'b1; d_rdata = 32'hDEAD_BEEF; d_rresp = 2'b10; d_rlast = 1'b1; d_rid = 4'h3; d_rready = 1'b1;
        #1;
        chk(up_rvalid[0] && up_rdata[0] == 32'hDEAD_BEEF && up_rresp[0] == 2'b10 && up_rlast[0] && up_rid[0] == 4'h3,
            "R5 data fields", 64'(up_rdata[0]), 64'h0DEAD_BEEF);
        chk(dn_rready[0] == 1'b1, "R5 ready passes", 64'(dn_rready[0]), 64'd1);
        @(negedge clk);
        d_rvalid = 1'b0; d_rready = 1'b0; d_rlast = 1'b0; #1;
        chk(dn_rready[0] == 1'b0 && up_rvalid[0] == 1'b0, "R5 idle",
            64'({dn_rready[0], up_rvalid[0]}), 64'd0);

        // four-path scenario, path 0 stalled (R6, R3)
        rst_n = 1'b0;
        @(negedge clk);
        hold = 4'b0001;
        for (int p = 0; p < NP; p++) begin
            want[p] = 8'd16;
            push_expected(p, 16);
        end
        xbar_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        begin
            int cyc;
            cyc = 0;
            while (!(rcvd[1] == 8'd16 && rcvd[2] == 8'd16 && rcvd[3] == 8'd16) && cyc < 3000) begin
                @(negedge clk); cyc++;
            end
            chk(cyc < 3000, "R6 other paths finish", 64'(cyc), 64'd3000);
            chk(sent[0] == 8'd0 && rcvd[0] == 8'd0, "R6 stalled path idle",
                64'(sent[0]), 64'd0);
            @(negedge clk); #1;
            chk(up_arvalid[0] && !dn_arvalid[0], "R7 held yet withdrawn",
                64'({up_arvalid[0], dn_arvalid[0]}), 64'({1'b1, 1'b0}));
            hold = 4'b0000;
            cyc = 0;
            while (rcvd[0] != 8'd16 && cyc < 3000) begin
                @(negedge clk); cyc++;
            end
            chk(cyc < 3000, "R6 released path finishes", 64'(rcvd[0]), 64'd16);
        end
        repeat (4) @(negedge clk);
        for (int p = 0; p < NP; p++)
            chk(exp_q[p].size() == 0, "R6 scoreboard drained", 64'(exp_q[p].size()), 64'd0);
        chk(stall_hs == 0, "R3 no handshake while stalled", 64'(stall_hs), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule